// File: doc/BRIEF.md
# RZ/NRZ Low-Speed Data Front End

This block takes slow asynchronous line data and turns it into single-cycle event strobes for a downstream word encoder. A format pin picks the line coding. In return-to-zero (RZ) coding, each of the two data lines carries pulses. One line is the MARK line and the other is the SPACE line. In non-return-to-zero (NRZ) coding, the first data line carries the data, and every level change on it is one event. The second line then carries a slow secondary control level.

The MARK/SPACE assignment is not wired in. It is learned from the lines themselves. While the active-low call-enable input is high, the block records which data line toggled most recently. When call-enable falls, that line becomes the MARK line, and the assignment stays fixed for as long as call-enable stays low.

A single gap timer counts cycles since the last primary-line event. It serves two purposes:
- It flags events that arrive closer than the minimum legal spacing.
- It gates the secondary control sample, so that the sample is taken only after the primary line has been quiet for that spacing.

All four pins pass through synchronizers before any edge logic. The default spacing is 256 cycles, which is 125 µs at a 2.048 MHz clock.

Top module: `lsfe_front`

## Requirements
- R1: After reset, `evt_valid`, `evt_mark`, `spacing_err`, `mark_on_b` and `sec_level` are all 0.
- R2: In RZ mode (`fmt_rz`=1), during a call, each rising edge on a data line produces one `evt_valid` strobe. `evt_mark` is 1 when that line is the MARK line (line B when `mark_on_b`=1, line A when `mark_on_b`=0) and 0 otherwise. Falling edges produce nothing.
- R3: When synchronized `call_en_n` falls, `mark_on_b` takes the value 1 if the most recent transition, in either direction, was on line B, and 0 if it was on line A.
- R4: While `call_en_n` stays low, `mark_on_b` does not change, whatever the data lines do.
- R5: While `call_en_n` is high, no `evt_valid` strobe is produced. Line activity is still tracked for R3.
- R6: Back-to-back pulses on the same line, as with violation pulses, are each reported as a separate event carrying that line's tag.
- R7: In NRZ mode (`fmt_rz`=0), during a call, each transition of line A produces one event with `evt_mark` equal to the new level of line A (1 = high). Transitions on line B produce no event.
- R8: `spacing_err` is 1 together with an event exactly when fewer than QUIET_CYCLES cycles have passed since the previous primary edge. Primary edges are rising edges on either line in RZ mode and any edge of line A in NRZ mode, and edges outside a call count too. The first primary edge after reset is never flagged. `spacing_err` is never 1 without `evt_valid`.
- R9: In NRZ mode, `sec_level` follows synchronized line B only once at least QUIET_CYCLES cycles have passed since the last primary edge. Otherwise it holds its value.
- R10: In RZ mode, `sec_level` holds its value.
- R11: Every output changes three clock cycles after the pin change that causes it: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_rz | input | 1 | Coding select: 1 = RZ, 0 = NRZ |
| line_a | input | 1 | Data line A (primary line in NRZ mode) |
| line_b | input | 1 | Data line B (secondary control line in NRZ mode) |
| call_en_n | input | 1 | Active-low call enable; its falling edge latches polarity |
| evt_valid | output | 1 | Single-cycle event strobe |
| evt_mark | output | 1 | Event tag: 1 = MARK, 0 = SPACE |
| spacing_err | output | 1 | Event arrived below minimum spacing |
| mark_on_b | output | 1 | 1 = line B is the MARK line |
| sec_level | output | 1 | Gated secondary control level |

## Verification
Each piece of internal state shows up at the ports quickly:
- A wrong last-active-line record appears as an inverted `mark_on_b` three cycles after call-enable falls. After that, every RZ event tag is inverted.
- A gap timer that restarts on the wrong edges, or saturates one count off, shows up as `spacing_err` on the wrong side of the spacing boundary. It also shows up as `sec_level` updating too early or never.

The bench therefore sweeps event gaps just below, at and just above the spacing limit. It learns polarity from both lines and samples every output exactly three cycles after each stimulus.

// File: rtl/lsfe_pkg.sv
package lsfe_pkg;

    localparam int unsigned NUM_PINS = 4;
    localparam int unsigned PIN_FMT  = 0;
    localparam int unsigned PIN_A    = 1;
    localparam int unsigned PIN_B    = 2;
    localparam int unsigned PIN_CEN  = 3;

    // idle pin levels: call enable deasserted (high), data lines low, NRZ
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1000;

    typedef struct packed {
        logic valid;
        logic mark;
        logic err;
    } evt_t;

    typedef struct packed {
        logic prev_a;
        logic prev_b;
        logic prev_cen;
        logic last_b;
        logic mark_on_b;
        logic sec;
        evt_t evt;
    } front_state_t;

endpackage

// File: rtl/lsfe_sync.sv
module lsfe_sync #(
    parameter int unsigned       WIDTH   = 4,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/lsfe_gap_timer.sv
module lsfe_gap_timer #(
    parameter int unsigned QUIET_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic quiet
);

    localparam int unsigned CW = (QUIET_CYCLES > 2) ? $clog2(QUIET_CYCLES) : 1;
    localparam logic [CW-1:0] SAT = CW'(QUIET_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q == SAT) begin
            cnt_d = SAT;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign quiet = (cnt_q == SAT);

endmodule

// File: rtl/lsfe_front.sv
module lsfe_front
    import lsfe_pkg::*;
#(
    parameter int unsigned QUIET_CYCLES = 256,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_rz,
    input  logic line_a,
    input  logic line_b,
    input  logic call_en_n,
    output logic evt_valid,
    output logic evt_mark,
    output logic spacing_err,
    output logic mark_on_b,
    output logic sec_level
);

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    logic                fmt_s, a_s, b_s, cen_s;
    logic                prim_edge, gap_quiet;
    front_state_t        st_d, st_q;

    assign pins_raw[PIN_FMT] = fmt_rz;
    assign pins_raw[PIN_A]   = line_a;
    assign pins_raw[PIN_B]   = line_b;
    assign pins_raw[PIN_CEN] = call_en_n;

    lsfe_sync #(
        .WIDTH   (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    assign fmt_s = pins_s[PIN_FMT];
    assign a_s   = pins_s[PIN_A];
    assign b_s   = pins_s[PIN_B];
    assign cen_s = pins_s[PIN_CEN];

    lsfe_gap_timer #(
        .QUIET_CYCLES (QUIET_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (prim_edge),
        .quiet   (gap_quiet)
    );

    logic a_rise, b_rise, a_tog, b_tog, in_call, call_start;

    always_comb begin
        st_d = st_q;

        a_tog      = a_s ^ st_q.prev_a;
        b_tog      = b_s ^ st_q.prev_b;
        a_rise     = a_tog & a_s;
        b_rise     = b_tog & b_s;
        in_call    = ~cen_s & ~st_q.prev_cen;
        call_start = ~cen_s & st_q.prev_cen;

        st_d.prev_a   = a_s;
        st_d.prev_b   = b_s;
        st_d.prev_cen = cen_s;

        // most recent toggling line; line B wins a same-cycle tie
        if (a_tog || b_tog) begin
            st_d.last_b = b_tog;
        end

        if (call_start) begin
            st_d.mark_on_b = st_d.last_b;
        end

        prim_edge = fmt_s ? (a_rise | b_rise) : a_tog;

        st_d.evt.valid = prim_edge & in_call;
        st_d.evt.err   = prim_edge & in_call & ~gap_quiet;
        if (fmt_s) begin
            st_d.evt.mark = a_rise ? ~st_q.mark_on_b : st_q.mark_on_b;
        end else begin
            st_d.evt.mark = a_s;
        end
        if (!st_d.evt.valid) begin
            st_d.evt.mark = 1'b0;
        end

        if (!fmt_s && gap_quiet && !prim_edge) begin
            st_d.sec = b_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.prev_cen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_valid   = st_q.evt.valid;
    assign evt_mark    = st_q.evt.mark;
    assign spacing_err = st_q.evt.err;
    assign mark_on_b   = st_q.mark_on_b;
    assign sec_level   = st_q.sec;

endmodule

// File: rtl/lsfe_front_chk.sv
module lsfe_front_chk (
    input logic clk,
    input logic rst_n,
    input logic fmt_rz,
    input logic call_en_n,
    input logic evt_valid,
    input logic spacing_err,
    input logic mark_on_b,
    input logic sec_level
);

    p_err_needs_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |-> evt_valid)
        else $error("spacing_err without event");

    p_polarity_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_en_n && !$past(call_en_n) && !$past(call_en_n, 2)
         && !$past(call_en_n, 3) && !$past(call_en_n, 4)) |-> $stable(mark_on_b))
        else $error("polarity moved during call");

    p_no_evt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en_n && $past(call_en_n) && $past(call_en_n, 2)
         && $past(call_en_n, 3) && $past(call_en_n, 4)) |-> !evt_valid)
        else $error("event outside call");

    p_sec_hold_rz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_rz && $past(fmt_rz) && $past(fmt_rz, 2)
         && $past(fmt_rz, 3) && $past(fmt_rz, 4)) |-> $stable(sec_level))
        else $error("secondary level moved in RZ mode");

endmodule

bind lsfe_front lsfe_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_rz      (fmt_rz),
    .call_en_n   (call_en_n),
    .evt_valid   (evt_valid),
    .spacing_err (spacing_err),
    .mark_on_b   (mark_on_b),
    .sec_level   (sec_level)
);

// File: tb/lsfe_front_bench.sv
module lsfe_front_bench;

    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_rz = 1'b1;
    logic line_a = 1'b0;
    logic line_b = 1'b0;
    logic call_en_n = 1'b1;
    logic evt_valid, evt_mark, spacing_err, mark_on_b, sec_level;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int last_prim = -100000;
    bit done     = 1'b0;
    logic exp_mark_b = 1'b0;
    logic exp_last_b = 1'b0;
    logic exp_sec    = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lsfe_front #(.QUIET_CYCLES(Q), .SYNC_STAGES(2)) u_lsfe_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_rz      (fmt_rz),
        .line_a      (line_a),
        .line_b      (line_b),
        .call_en_n   (call_en_n),
        .evt_valid   (evt_valid),
        .evt_mark    (evt_mark),
        .spacing_err (spacing_err),
        .mark_on_b   (mark_on_b),
        .sec_level   (sec_level)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // output appears three edges after a negedge drive (R11)
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic prim_err();
        logic e;
        e = (cyc - last_prim) < Q;
        last_prim = cyc;
        return e;
    endfunction

    task automatic rz_pulse(input bit on_b, input bit call);
        logic e;
        if (on_b) line_b = 1'b1; else line_a = 1'b1;
        e = prim_err();
        exp_last_b = on_b;
        settle();
        check(call ? "R2 valid" : "R5 idle", evt_valid, call);
        if (call) begin
            check("R2 tag", evt_mark, (on_b == exp_mark_b));
            check("R8 err", spacing_err, e);
        end
        check("R10 sec", sec_level, exp_sec);
        if (on_b) line_b = 1'b0; else line_a = 1'b0;
    endtask

    task automatic nrz_toggle_a();
        logic e;
        line_a = ~line_a;
        e = prim_err();
        exp_last_b = 1'b0;
        settle();
        check("R7 valid", evt_valid, 1'b1);
        check("R7 tag", evt_mark, line_a);
        check("R8 err", spacing_err, e);
    endtask

    task automatic start_call();
        call_en_n = 1'b0;
        exp_mark_b = exp_last_b;
        settle();
        check("R3 polarity", mark_on_b, exp_mark_b);
        wait_n(2);
    endtask

    task automatic end_call();
        call_en_n = 1'b1;
        settle();
        wait_n(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        check("R1 evt_valid", evt_valid, 1'b0);
        check("R1 evt_mark", evt_mark, 1'b0);
        check("R1 spacing_err", spacing_err, 1'b0);
        check("R1 mark_on_b", mark_on_b, 1'b0);
        check("R1 sec_level", sec_level, 1'b0);

        // R5: idle activity produces no events; last toggler B
        rz_pulse(1'b0, 1'b0);
        wait_n(20);
        rz_pulse(1'b1, 1'b0);
        wait_n(20);
        start_call();

        // R2 / R8: gap sweep around the spacing limit, alternating lines
        wait_n(Q + 4);
        for (int g = Q - 3; g <= Q + 2; g++) begin
            rz_pulse(g[0], 1'b1);
            wait_n(g - 3);
        end
        // R6: repeated pulses on one line, each tagged by its line
        for (int k = 0; k < 3; k++) begin
            rz_pulse(1'b1, 1'b1);
            wait_n(Q);
        end
        rz_pulse(1'b0, 1'b1);
        wait_n(Q);
        rz_pulse(1'b0, 1'b1);
        wait_n(10);
        // R4: last toggler is now A, polarity still B
        check("R4 frozen", mark_on_b, 1'b1);

        end_call();
        check("R4 frozen after", mark_on_b, 1'b1);
        wait_n(Q);
        rz_pulse(1'b0, 1'b0);
        wait_n(Q);
        start_call();
        wait_n(Q);
        rz_pulse(1'b0, 1'b1);
        wait_n(Q);
        rz_pulse(1'b1, 1'b1);
        wait_n(Q);
        end_call();

        // NRZ: secondary level capture (R9)
        fmt_rz = 1'b0;
        wait_n(Q + 10);
        check("R9 sec idle", sec_level, 1'b0);
        line_b = 1'b1;
        wait_n(Q + 10);
        exp_sec = 1'b1;
        check("R9 sec quiet", sec_level, exp_sec);
        start_call();
        wait_n(Q);

        // R7 / R8 in NRZ with gap sweep
        for (int g = Q - 2; g <= Q + 1; g++) begin
            nrz_toggle_a();
            wait_n(g - 3);
        end
        // line B change: no event (R7), not captured right after A edge (R9)
        wait_n(Q);
        nrz_toggle_a();
        line_b = 1'b0;
        settle();
        check("R7 B no event", evt_valid, 1'b0);
        check("R9 sec gated", sec_level, exp_sec);
        wait_n(Q + 5);
        exp_sec = 1'b0;
        check("R9 sec after quiet", sec_level, exp_sec);
        end_call();

        // R10: RZ mode holds secondary level
        line_b = 1'b0;
        fmt_rz = 1'b1;
        wait_n(10);
        rz_pulse(1'b1, 1'b0);
        wait_n(Q + 5);
        check("R10 sec hold", sec_level, exp_sec);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule